// File: doc/BRIEF.md
# Absolute-Address Store Sequencer

This block executes the store-to-absolute-address instruction group of an 8-bit processor. It handles the following forms:

- the accumulator store;
- the HL store with a one-byte opcode;
- the two index-register stores selected by a prefix byte;
- the four register-pair stores behind a third prefix byte.

Each form takes a 16-bit target address from the instruction stream. Single bytes go to that address. Word values go low byte first, with the high byte at the next address.

A start request from the surrounding core launches the sequence. From then on the block pulls each instruction byte itself. It raises `ifetch_take` on the clock in which it samples `ifetch_byte`. The register file is read through plain input buses and is never written. Memory writes leave on a byte-wide port with a one-clock write strobe.

The block keeps the exact clock budget of each form. The budget is cut into steps of two clocks per fetched byte, one internal clock and three clocks per memory write. A `done` pulse marks the final clock of the instruction. A byte sequence outside the group ends the attempt with a one-clock `illegal` pulse instead.

Top module: `store_direct_seq`

## Requirements
- R1: Lead byte 0x32 followed by address bytes lo, hi writes `rf_a` to address {hi,lo} once. The write strobe is at clock 10, and `done` is at clock 10. Clock 1 is the first clock with `busy` high.
- R2: Lead byte 0x22 followed by lo, hi writes `rf_hl[7:0]` to mn at clock 10 and `rf_hl[15:8]` to mn+1 at clock 13. `done` is at clock 13.
- R3: Prefix 0xDD then 0x22 stores `rf_ix`, and prefix 0xFD then 0x22 stores `rf_iy`. The low byte goes to mn at clock 12 and the high byte to mn+1 at clock 15. `done` is at clock 15.
- R4: Prefix 0xED followed by 0x43, 0x53, 0x63 or 0x73 stores BC, DE, HL or SP respectively. Bits 5:4 of the second byte pick the pair. The timing is the same as R3.
- R5: Instruction bytes are sampled only at the end of each two-clock fetch step. `ifetch_take` is high in clocks 2, 4 and 6, plus clock 8 for prefixed forms, and in no other clock.
- R6: The address bytes arrive low byte first. The second write address is mn+1 modulo 65536, so 0xFFFF is followed by 0x0000.
- R7: `mem_we` is high for one clock only, the last clock of a three-clock write step. `mem_addr` and `mem_wdata` hold the same values through all three clocks of that step.
- R8: A lead byte other than 0x32, 0x22, 0xDD, 0xFD or 0xED raises `illegal` for exactly one clock, in clock 3. A second byte outside the group after a prefix raises it in clock 5. Neither case writes memory or raises `done`, and `busy` is low on the next clock.
- R9: `done` is a single-clock pulse. When `ifetch_valid` is high during the `done` clock, the next instruction's clock 1 follows with no idle clock between.
- R10: While reset is held, and while idle after it, `busy`, `done`, `illegal`, `mem_we` and `ifetch_take` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifetch_valid | input | 1 | Start request, sampled when idle or in the final clock |
| ifetch_byte | input | 8 | Instruction byte stream |
| ifetch_take | output | 1 | The byte on `ifetch_byte` is consumed this clock |
| rf_a | input | 8 | Accumulator value |
| rf_bc | input | 16 | BC pair value |
| rf_de | input | 16 | DE pair value |
| rf_hl | input | 16 | HL pair value |
| rf_sp | input | 16 | Stack pointer value |
| rf_ix | input | 16 | First index register value |
| rf_iy | input | 16 | Second index register value |
| mem_addr | output | 16 | Write address, zero outside write steps |
| mem_wdata | output | 8 | Write data, zero outside write steps |
| mem_we | output | 1 | Write strobe |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Final clock of a completed instruction |
| illegal | output | 1 | Unrecognized byte sequence ended the attempt |

## Verification
The state that matters lives in the step counter, the prefix flag and the selected source. A miscounted step shows at the ports at once: it moves an `ifetch_take` to an odd clock, shifts the write strobe or `done` by one clock, or breaks address stability inside a write step. A wrong prefix flag or source choice has two possible symptoms. Either `done` lands at 13 instead of 15, or the wrong register's bytes appear on the first write. Both are visible within the same instruction. Sweeping every lead byte and every second byte behind each prefix shows any decode error on `illegal` no later than clock 5.

// File: rtl/sds_pkg.sv
package sds_pkg;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int MAX_LEN = 15;

  typedef enum logic [2:0] {
    SRC_A, SRC_BC, SRC_DE, SRC_HL, SRC_SP, SRC_IX, SRC_IY
  } src_e;

  typedef struct packed {
    logic bad;
    logic pfx;
    src_e src;
  } dec_t;

  // First byte of an instruction: direct store, prefix, or foreign.
  function automatic dec_t dec_lead(input logic [7:0] b);
    dec_t r;
    r = '{bad: 1'b0, pfx: 1'b0, src: SRC_A};
    case (b)
      8'h32:               r.src = SRC_A;
      8'h22:               r.src = SRC_HL;
      8'hDD, 8'hFD, 8'hED: r.pfx = 1'b1;
      default:             r.bad = 1'b1;
    endcase
    return r;
  endfunction

  // Opcode byte that follows a prefix.
  function automatic dec_t dec_tail(input logic [7:0] lead, input logic [7:0] b);
    dec_t r;
    r = '{bad: 1'b1, pfx: 1'b1, src: SRC_A};
    if (lead == 8'hED) begin
      case (b)
        8'h43: begin r.bad = 1'b0; r.src = SRC_BC; end
        8'h53: begin r.bad = 1'b0; r.src = SRC_DE; end
        8'h63: begin r.bad = 1'b0; r.src = SRC_HL; end
        8'h73: begin r.bad = 1'b0; r.src = SRC_SP; end
        default: r.bad = 1'b1;
      endcase
    end else if (b == 8'h22) begin
      r.bad = 1'b0;
      r.src = (lead == 8'hDD) ? SRC_IX : SRC_IY;
    end
    return r;
  endfunction

  // Total clock budget of a decoded form.
  function automatic int op_len(input logic pfx, input src_e s);
    if (pfx) return 15;
    return (s == SRC_A) ? 10 : 13;
  endfunction

  // Address of the high byte of a word store.
  function automatic logic [WORD_W-1:0] next_addr(input logic [WORD_W-1:0] a);
    return a + WORD_W'(1);
  endfunction

endpackage

// File: rtl/sds_ctrl.sv
module sds_ctrl
  import sds_pkg::*;
#(
  parameter int BYTE_W = sds_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] fetch_byte,
  output logic              take,
  output logic              lo_cyc,
  output logic              hi_cyc,
  output logic              cap_cyc,
  output logic              wr1_step,
  output logic              wr2_step,
  output logic              we,
  output logic              done,
  output logic              illegal,
  output logic              busy,
  output src_e              src
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0]  cyc;
  logic [CNT_W-1:0]  off;
  logic [CNT_W-1:0]  len;
  logic [BYTE_W-1:0] lead_q;
  logic              pfx_q;
  logic              ill_q;
  logic              wide;
  logic              lead_cyc;
  logic              tail_cyc;
  logic              finish;
  src_e              src_q;
  dec_t              lead_d;
  dec_t              tail_d;

  always_comb begin
    busy     = (cyc != '0);
    off      = pfx_q ? CNT_W'(2) : '0;
    wide     = (src_q != SRC_A);
    len      = CNT_W'(op_len(pfx_q, src_q));
    lead_d   = dec_lead(fetch_byte);
    tail_d   = dec_tail(lead_q, fetch_byte);
    lead_cyc = (cyc == CNT_W'(2));
    tail_cyc = pfx_q && (cyc == CNT_W'(4));
    take     = busy && !ill_q && !cyc[0] && (cyc <= CNT_W'(6) + off);
    lo_cyc   = !ill_q && (cyc == CNT_W'(4) + off);
    hi_cyc   = !ill_q && (cyc == CNT_W'(6) + off);
    cap_cyc  = (cyc == CNT_W'(7) + off);
    wr1_step = (cyc >= CNT_W'(8) + off) && (cyc <= CNT_W'(10) + off);
    wr2_step = wide && (cyc >= CNT_W'(11) + off) && (cyc <= CNT_W'(13) + off);
    we       = (cyc == CNT_W'(10) + off) || (wide && (cyc == CNT_W'(13) + off));
    done     = busy && !ill_q && (cyc == len);
    illegal  = ill_q;
    finish   = done || ill_q;
    src      = src_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= '0;
      lead_q <= '0;
      pfx_q  <= 1'b0;
      ill_q  <= 1'b0;
      src_q  <= SRC_A;
    end else if (!busy || finish) begin
      cyc   <= start ? CNT_W'(1) : '0;
      pfx_q <= 1'b0;
      ill_q <= 1'b0;
      src_q <= SRC_A;
    end else begin
      cyc <= cyc + CNT_W'(1);
      if (lead_cyc) begin
        lead_q <= fetch_byte;
        pfx_q  <= lead_d.pfx;
        src_q  <= lead_d.src;
        ill_q  <= lead_d.bad;
      end
      if (tail_cyc) begin
        src_q <= tail_d.src;
        ill_q <= tail_d.bad;
      end
    end
  end

endmodule

// File: rtl/sds_addr.sv
module sds_addr
  import sds_pkg::*;
#(
  parameter int BYTE_W = sds_pkg::BYTE_W,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] fetch_byte,
  input  logic              lo_cyc,
  input  logic              hi_cyc,
  input  logic              wr1_step,
  input  logic              wr2_step,
  output logic [WORD_W-1:0] mem_addr
);
  logic [WORD_W-1:0] mn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mn_q <= '0;
    else begin
      if (lo_cyc) mn_q[BYTE_W-1:0]      <= fetch_byte;
      if (hi_cyc) mn_q[WORD_W-1:BYTE_W] <= fetch_byte;
    end
  end

  always_comb begin
    if (wr1_step)      mem_addr = mn_q;
    else if (wr2_step) mem_addr = next_addr(mn_q);
    else               mem_addr = '0;
  end

endmodule

// File: rtl/sds_data.sv
module sds_data
  import sds_pkg::*;
#(
  parameter int BYTE_W = sds_pkg::BYTE_W,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_e              src,
  input  logic              cap_cyc,
  input  logic              wr1_step,
  input  logic              wr2_step,
  input  logic [BYTE_W-1:0] rf_a,
  input  logic [WORD_W-1:0] rf_bc,
  input  logic [WORD_W-1:0] rf_de,
  input  logic [WORD_W-1:0] rf_hl,
  input  logic [WORD_W-1:0] rf_sp,
  input  logic [WORD_W-1:0] rf_ix,
  input  logic [WORD_W-1:0] rf_iy,
  output logic [BYTE_W-1:0] mem_wdata
);
  logic [WORD_W-1:0] pick;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    case (src)
      SRC_BC:  pick = rf_bc;
      SRC_DE:  pick = rf_de;
      SRC_HL:  pick = rf_hl;
      SRC_SP:  pick = rf_sp;
      SRC_IX:  pick = rf_ix;
      SRC_IY:  pick = rf_iy;
      default: pick = {{BYTE_W{1'b0}}, rf_a};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= '0;
    else if (cap_cyc) word_q <= pick;
  end

  always_comb begin
    if (wr1_step)      mem_wdata = word_q[BYTE_W-1:0];
    else if (wr2_step) mem_wdata = word_q[WORD_W-1:BYTE_W];
    else               mem_wdata = '0;
  end

endmodule

// File: rtl/store_direct_seq.sv
module store_direct_seq
  import sds_pkg::*;
#(
  parameter int BYTE_W = sds_pkg::BYTE_W,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifetch_valid,
  input  logic [BYTE_W-1:0] ifetch_byte,
  output logic              ifetch_take,
  input  logic [BYTE_W-1:0] rf_a,
  input  logic [WORD_W-1:0] rf_bc,
  input  logic [WORD_W-1:0] rf_de,
  input  logic [WORD_W-1:0] rf_hl,
  input  logic [WORD_W-1:0] rf_sp,
  input  logic [WORD_W-1:0] rf_ix,
  input  logic [WORD_W-1:0] rf_iy,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  logic lo_cyc, hi_cyc, cap_cyc, wr1_step, wr2_step;
  src_e src;

  sds_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(ifetch_valid), .fetch_byte(ifetch_byte),
    .take(ifetch_take), .lo_cyc(lo_cyc), .hi_cyc(hi_cyc), .cap_cyc(cap_cyc),
    .wr1_step(wr1_step), .wr2_step(wr2_step), .we(mem_we), .done(done),
    .illegal(illegal), .busy(busy), .src(src)
  );

  sds_addr #(.BYTE_W(BYTE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .fetch_byte(ifetch_byte), .lo_cyc(lo_cyc),
    .hi_cyc(hi_cyc), .wr1_step(wr1_step), .wr2_step(wr2_step), .mem_addr(mem_addr)
  );

  sds_data #(.BYTE_W(BYTE_W)) u_data (
    .clk(clk), .rst_n(rst_n), .src(src), .cap_cyc(cap_cyc), .wr1_step(wr1_step),
    .wr2_step(wr2_step), .rf_a(rf_a), .rf_bc(rf_bc), .rf_de(rf_de), .rf_hl(rf_hl),
    .rf_sp(rf_sp), .rf_ix(rf_ix), .rf_iy(rf_iy), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/sds_checker.sv
module sds_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ifetch_take,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        mem_we,
  input logic        busy,
  input logic        done,
  input logic        illegal
);
  assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_step_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_addr) == mem_addr) && ($past(mem_addr, 2) == mem_addr)
               && ($past(mem_wdata) == mem_wdata) && ($past(mem_wdata, 2) == mem_wdata));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we, 3)) |-> (mem_addr == 16'($past(mem_addr, 3) + 16'd1)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_we && !done && !ifetch_take));

  assert_illegal_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !done && !illegal && !ifetch_take));
endmodule

bind store_direct_seq sds_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ifetch_take(ifetch_take), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done), .illegal(illegal)
);

// File: tb/store_direct_seq_tb.sv
module store_direct_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ifetch_valid = 1'b0;
  logic [7:0]  ifetch_byte = 8'h00;
  logic        ifetch_take;
  logic [7:0]  rf_a = 8'h00;
  logic [15:0] rf_bc = '0, rf_de = '0, rf_hl = '0, rf_sp = '0, rf_ix = '0, rf_iy = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, busy, done, illegal;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [7:0] fb [4];
  int idx;
  logic        take_h [20];
  logic        we_h   [20];
  logic        done_h [20];
  logic        ill_h  [20];
  logic        busy_h [20];
  logic [15:0] addr_h [20];
  logic [7:0]  data_h [20];

  always #4 clk = ~clk;

  store_direct_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ifetch_valid(ifetch_valid), .ifetch_byte(ifetch_byte),
    .ifetch_take(ifetch_take), .rf_a(rf_a), .rf_bc(rf_bc), .rf_de(rf_de), .rf_hl(rf_hl),
    .rf_sp(rf_sp), .rf_ix(rf_ix), .rf_iy(rf_iy), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done), .illegal(illegal)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  task automatic new_regs();
    rf_a  = rnd16()[7:0];
    rf_bc = rnd16(); rf_de = rnd16(); rf_hl = rnd16();
    rf_sp = rnd16(); rf_ix = rnd16(); rf_iy = rnd16();
  endtask

  // ill_at: 0 for a legal form, else the clock expected to carry the illegal pulse.
  task automatic run_op(input logic [7:0] b0, b1, b2, b3, input int ill_at,
                        input bit pref, input bit wide, input logic [15:0] word,
                        input logic [15:0] mn, input string rq,
                        input bit pre, input bit chain);
    int len, o, last, nwe, ndone, nill, illc, donec;
    int wc [2];
    logic [31:0] mask, emask;
    logic [15:0] mn1;
    fb[0] = b0; fb[1] = b1; fb[2] = b2; fb[3] = b3;
    idx = 0;
    o = pref ? 2 : 0;
    len = pref ? 15 : (wide ? 13 : 10);
    last = (ill_at != 0) ? ill_at + 1 : (chain ? len : len + 1);
    if (!pre) begin
      @(negedge clk);
      ifetch_valid = 1'b1;
    end
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == 1) ifetch_valid = 1'b0;
      take_h[k] = ifetch_take; we_h[k] = mem_we; done_h[k] = done;
      ill_h[k] = illegal; busy_h[k] = busy; addr_h[k] = mem_addr; data_h[k] = mem_wdata;
      ifetch_byte = (idx < 4) ? fb[idx] : 8'h00;
      if (ifetch_take) idx++;
      if (chain && ill_at == 0 && k == len) ifetch_valid = 1'b1;
    end
    mask = '0; nwe = 0; ndone = 0; nill = 0; illc = 0; donec = 0; wc[0] = 0; wc[1] = 0;
    for (int k = 1; k <= last; k++) begin
      if (take_h[k]) mask[k] = 1'b1;
      if (we_h[k]) begin if (nwe < 2) wc[nwe] = k; nwe++; end
      if (done_h[k]) begin ndone++; donec = k; end
      if (ill_h[k]) begin nill++; illc = k; end
    end
    if (ill_at != 0) begin
      emask = (ill_at == 3) ? 32'h4 : 32'h14;
      chk(mask == emask, "R5", "fetch clocks before illegal", mask, emask);
      chk(nill == 1 && illc == ill_at, "R8", "illegal pulse clock", illc, ill_at);
      chk(nwe == 0 && ndone == 0, "R8", "no write or done", nwe + ndone, 0);
      chk(!busy_h[last], "R8", "idle after illegal", busy_h[last], 0);
    end else begin
      emask = pref ? 32'h154 : 32'h54;
      mn1 = mn + 16'd1;
      chk(mask == emask, "R5", "fetch clocks", mask, emask);
      chk(nill == 0, rq, "no illegal", nill, 0);
      chk(nwe == (wide ? 2 : 1), rq, "write count", nwe, wide ? 2 : 1);
      chk(wc[0] == 10 + o, "R5", "first write clock", wc[0], 10 + o);
      if (wc[0] >= 3) begin
        chk(addr_h[wc[0]] == mn, rq, "first address", addr_h[wc[0]], mn);
        chk(data_h[wc[0]] == word[7:0], rq, "first data", data_h[wc[0]], word[7:0]);
        chk(addr_h[wc[0]-1] == mn && addr_h[wc[0]-2] == mn &&
            data_h[wc[0]-1] == word[7:0] && data_h[wc[0]-2] == word[7:0],
            "R7", "first step stable", addr_h[wc[0]-2], mn);
      end
      if (wide) begin
        chk(wc[1] == 13 + o, "R5", "second write clock", wc[1], 13 + o);
        if (wc[1] >= 3) begin
          chk(addr_h[wc[1]] == mn1, "R6", "second address", addr_h[wc[1]], mn1);
          chk(data_h[wc[1]] == word[15:8], rq, "second data", data_h[wc[1]], word[15:8]);
          chk(addr_h[wc[1]-1] == mn1 && addr_h[wc[1]-2] == mn1 &&
              data_h[wc[1]-1] == word[15:8] && data_h[wc[1]-2] == word[15:8],
              "R7", "second step stable", addr_h[wc[1]-2], mn1);
        end
      end
      chk(ndone == 1 && donec == len, rq, "done clock", donec, len);
      if (!chain) chk(!busy_h[last], "R9", "idle after done", busy_h[last], 0);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] mn;
    logic [15:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, illegal, mem_we, ifetch_take} == 5'b0, "R10", "outputs in reset",
        {busy, done, illegal, mem_we, ifetch_take}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, illegal, mem_we, ifetch_take} == 5'b0, "R10", "outputs idle",
        {busy, done, illegal, mem_we, ifetch_take}, 0);

    // R1 accumulator store, including the top of the address space
    foreach (fb[i]) fb[i] = 8'h00;
    for (int t = 0; t < 4; t++) begin
      new_regs();
      mn = (t == 3) ? 16'hFFFF : rnd16();
      run_op(8'h32, mn[7:0], mn[15:8], 8'h00, 0, 1'b0, 1'b0, {8'h00, rf_a}, mn, "R1", 1'b0, 1'b0);
    end
    // R2 HL store, with R6 wrap case
    for (int t = 0; t < 4; t++) begin
      new_regs();
      mn = (t == 0) ? 16'hFFFF : rnd16();
      run_op(8'h22, mn[7:0], mn[15:8], 8'h00, 0, 1'b0, 1'b1, rf_hl, mn, "R2", 1'b0, 1'b0);
    end
    // R3 index register stores
    for (int t = 0; t < 3; t++) begin
      new_regs();
      mn = (t == 0) ? 16'hFFFF : rnd16();
      run_op(8'hDD, 8'h22, mn[7:0], mn[15:8], 0, 1'b1, 1'b1, rf_ix, mn, "R3", 1'b0, 1'b0);
      run_op(8'hFD, 8'h22, mn[7:0], mn[15:8], 0, 1'b1, 1'b1, rf_iy, mn, "R3", 1'b0, 1'b0);
    end
    // R4 register pair stores, pair chosen by bits 5:4
    for (int p = 0; p < 4; p++) begin
      new_regs();
      mn = (p == 3) ? 16'hFFFF : rnd16();
      w = (p == 0) ? rf_bc : (p == 1) ? rf_de : (p == 2) ? rf_hl : rf_sp;
      run_op(8'hED, 8'h43 + 8'(p * 16), mn[7:0], mn[15:8], 0, 1'b1, 1'b1, w, mn, "R4", 1'b0, 1'b0);
    end
    // R9 back-to-back chain of three instructions
    new_regs();
    run_op(8'h32, 8'h10, 8'h20, 8'h00, 0, 1'b0, 1'b0, {8'h00, rf_a}, 16'h2010, "R9", 1'b0, 1'b1);
    run_op(8'hED, 8'h73, 8'h34, 8'h12, 0, 1'b1, 1'b1, rf_sp, 16'h1234, "R9", 1'b1, 1'b1);
    run_op(8'h22, 8'hFF, 8'hFF, 8'h00, 0, 1'b0, 1'b1, rf_hl, 16'hFFFF, "R9", 1'b1, 1'b0);

    // R8 sweep of every lead byte outside the group
    for (int b = 0; b < 256; b++) begin
      if (b == 8'h32 || b == 8'h22 || b == 8'hDD || b == 8'hFD || b == 8'hED) continue;
      run_op(8'(b), 8'h22, 8'h00, 8'h00, 3, 1'b0, 1'b0, 16'h0, 16'h0, "R8", 1'b0, 1'b0);
    end
    // R8 / R3 / R4 sweep of every byte behind each prefix
    for (int pi = 0; pi < 3; pi++) begin
      logic [7:0] pb;
      pb = (pi == 0) ? 8'hDD : (pi == 1) ? 8'hFD : 8'hED;
      for (int b = 0; b < 256; b++) begin
        logic [7:0] ob;
        bit ok;
        ob = 8'(b);
        new_regs();
        mn = rnd16();
        ok = 1'b0; w = '0;
        if (pb == 8'hED && ob[7:6] == 2'b01 && ob[3:0] == 4'h3) begin
          ok = 1'b1;
          case (ob[5:4]) 2'd0: w = rf_bc; 2'd1: w = rf_de; 2'd2: w = rf_hl; default: w = rf_sp; endcase
        end else if (pb != 8'hED && ob == 8'h22) begin
          ok = 1'b1;
          w = (pb == 8'hDD) ? rf_ix : rf_iy;
        end
        if (ok)
          run_op(pb, ob, mn[7:0], mn[15:8], 0, 1'b1, 1'b1, w, mn,
                 (pb == 8'hED) ? "R4" : "R3", 1'b0, 1'b0);
        else
          run_op(pb, ob, mn[7:0], mn[15:8], 5, 1'b1, 1'b1, 16'h0, mn, "R8", 1'b0, 1'b0);
      end
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule